// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two N-bit words with a single full adder that is used again for every bit position, one bit per clock. The running total lives in an accumulator shift register and the addend in a second shift register. On every enabled step both registers move one place toward the low end. The two low bits and a saved carry enter the full adder, and the sum bit enters the top of the accumulator. After N enabled steps the accumulator holds the sum modulo 2^N, and the carry flip-flop holds the carry out of the top bit.

A start pulse begins a pass. It always loads the addend. It loads the accumulator only when the load flag is set, so that a chain of passes can add several words into one total. The clock is never gated. A shift-enable input stalls a pass: all state holds while it is low. A one-cycle done pulse marks the end of each pass.

Top module: `serial_accum_adder`

## Requirements
- R1: After reset, acc is 0, carry_out is 0, busy is 0 and done is 0.
- R2: A start seen at a clock edge while busy is 0 loads b_in into the addend register and clears the carry. It loads a_in into the accumulator when load_a is 1 and keeps the accumulator when load_a is 0. busy reads 1 after that edge.
- R3: After N clock edges at which both busy and shift_en are 1, acc equals (A + B) mod 2^N, and carry_out equals bit N of A + B.
- R4: done is 1 for exactly one cycle, the cycle after the final step edge. busy reads 0 in that same cycle.
- R5: While shift_en is 0 during a pass, acc, carry_out and the step count hold. The pass ends only after N enabled steps.
- R6: A start seen while busy is 1 is ignored, and the pass in progress completes with its original operands.
- R7: A pass started with load_a at 0 adds the new addend to the current acc. A carry left by the previous pass does not enter the new sum.
- R8: A start seen in the cycle where done is 1 is accepted, and the new pass uses the just-finished acc.
- R9: Bits are summed lowest first. After k enabled steps, acc[N-1:N-k] holds bits k-1..0 of A + B.
- R10: The width parameter N is legal from 2 to 32 and defaults to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a pass when the block is idle |
| load_a | input | 1 | On start, also load a_in into the accumulator |
| shift_en | input | 1 | Allows a step; low stalls the pass |
| a_in | input | N | Initial accumulator value |
| b_in | input | N | Addend |
| acc | output | N | Accumulator contents |
| carry_out | output | 1 | Saved carry; after a pass, the carry out of the top bit |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
Two events can fall in the same cycle: the end of a pass and the start of the next one. The bench raises start in the cycle where done is high, with load_a low. It expects the second pass to add its addend to the total just completed, with the old carry cleared. A second coincidence is a start during an active pass. The bench judges it by checking that the final sum still matches the operands loaded first.

// File: rtl/serial_accum_adder.sv
module serial_accum_adder #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         load_a,
  input  logic         shift_en,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  output logic [N-1:0] acc,
  output logic         carry_out,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [N-1:0]  a_q, b_q;
  logic          c_q, busy_q, done_q;
  logic [CW-1:0] step_q;

  // R10: legal width range
  initial assert (N >= 2 && N <= 32);

  wire take   = start & ~busy_q;
  wire step   = busy_q & shift_en;
  wire fa_sum = a_q[0] ^ b_q[0] ^ c_q;
  wire fa_cy  = (a_q[0] & b_q[0]) | (c_q & (a_q[0] ^ b_q[0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        b_q    <= b_in;
        if (load_a) a_q <= a_in;
        c_q    <= 1'b0;
        step_q <= '0;
        busy_q <= 1'b1;
      end else if (step) begin
        a_q    <= {fa_sum, a_q[N-1:1]};
        b_q    <= {1'b0, b_q[N-1:1]};
        c_q    <= fa_cy;
        step_q <= step_q + 1'b1;
        if (step_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign acc       = a_q;
  assign carry_out = c_q;
  assign busy      = busy_q;
  assign done      = done_q;

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !carry_out));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_pass_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_hold_paused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shift_en) |=> ($stable(acc) && $stable(carry_out) && busy));

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !shift_en) |=> $stable(acc));
endmodule

// File: tb/sim_serial_accum_adder.sv
module sim_serial_accum_adder;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, load_a = 1'b0, shift_en = 1'b1;
  logic [N-1:0] a_in = '0, b_in = '0;
  logic [N-1:0] acc;
  logic         carry_out, busy, done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  serial_accum_adder #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .load_a(load_a),
    .shift_en(shift_en), .a_in(a_in), .b_in(b_in),
    .acc(acc), .carry_out(carry_out), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [N-1:0] a, input logic [N-1:0] b, input logic la);
    a_in = a; b_in = b; load_a = la; start = 1'b1;
    @(negedge clk);
    start = 1'b0; load_a = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 acc", acc, 0);
    chk("R1 carry", carry_out, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_add(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N:0] s = a + b;
    pulse_start(a, b, 1'b1);
    chk("R2 busy", busy, 1);
    chk("R2 carry", carry_out, 0);
    repeat (N - 1) @(negedge clk);
    chk("R4 not done early", done, 0);
    @(negedge clk);
    chk("R3 sum", acc, s[N-1:0]);
    chk("R3 carry", carry_out, s[N]);
    chk("R4 done", done, 1);
    chk("R4 busy low", busy, 0);
    @(negedge clk);
    chk("R4 done drops", done, 0);
  endtask

  task automatic t_lsb_first;
    logic [N:0] s = 8'hB7 + 8'h5C;
    pulse_start(8'hB7, 8'h5C, 1'b1);
    repeat (3) @(negedge clk);
    chk("R9 low bits on top", acc[N-1:N-3], s[2:0]);
    repeat (N - 3) @(negedge clk);
    chk("R9 final", acc, s[N-1:0]);
    @(negedge clk);
  endtask

  task automatic t_pause;
    logic [N:0] s = 8'h9C + 8'h6B;
    logic [N-1:0] snap;
    logic c_snap;
    pulse_start(8'h9C, 8'h6B, 1'b1);
    repeat (2) @(negedge clk);
    shift_en = 1'b0;
    snap = acc; c_snap = carry_out;
    repeat (4) @(negedge clk);
    chk("R5 acc held", acc, snap);
    chk("R5 carry held", carry_out, c_snap);
    chk("R5 still busy", busy, 1);
    // start during pause must be ignored too (R6)
    start = 1'b1; a_in = 8'h11; b_in = 8'h22; load_a = 1'b1;
    @(negedge clk);
    start = 1'b0; load_a = 1'b0;
    chk("R6 acc held", acc, snap);
    shift_en = 1'b1;
    repeat (N - 3) @(negedge clk);
    chk("R5 not done yet", done, 0);
    @(negedge clk);
    chk("R5 done after N steps", done, 1);
    chk("R5 sum", acc, s[N-1:0]);
    @(negedge clk);
  endtask

  task automatic t_busy_start;
    logic [N:0] s = 8'h3A + 8'h47;
    pulse_start(8'h3A, 8'h47, 1'b1);
    @(negedge clk);
    start = 1'b1; a_in = 8'hFF; b_in = 8'hFF; load_a = 1'b1;
    @(negedge clk);
    start = 1'b0; load_a = 1'b0;
    repeat (N - 2) @(negedge clk);
    chk("R6 sum unaffected", acc, s[N-1:0]);
    chk("R6 carry unaffected", carry_out, s[N]);
    chk("R6 done", done, 1);
    @(negedge clk);
  endtask

  task automatic t_accum_chain;
    logic [N:0] s1 = 8'hF0 + 8'h20;
    logic [N:0] s2 = s1[N-1:0] + 8'h05;
    logic [N:0] s3 = s2[N-1:0] + 8'hEE;
    pulse_start(8'hF0, 8'h20, 1'b1);
    repeat (N) @(negedge clk);
    chk("R7 first sum", acc, s1[N-1:0]);
    chk("R7 first carry", carry_out, s1[N]);
    // start in the done cycle, accumulate (R8)
    chk("R8 done present", done, 1);
    pulse_start(8'hAA, 8'h05, 1'b0);
    chk("R7 carry cleared", carry_out, 0);
    repeat (N) @(negedge clk);
    chk("R8 back-to-back sum", acc, s2[N-1:0]);
    chk("R7 no carry leak", carry_out, s2[N]);
    @(negedge clk);
    pulse_start(8'h00, 8'hEE, 1'b0);
    repeat (N) @(negedge clk);
    chk("R7 third sum", acc, s3[N-1:0]);
    chk("R7 third carry", carry_out, s3[N]);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add(8'h5A, 8'h33);
    t_add(8'hFF, 8'h01);
    t_add(8'h00, 8'h00);
    t_add(8'hFF, 8'hFF);
    t_add(8'h80, 8'h80);
    t_lsb_first();
    t_pause();
    t_busy_start();
    t_accum_chain();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule